// File: doc/BRIEF.md
# Slave Address Matcher with General Call

This block watches the address byte that follows a start condition while the device acts as a bus slave. It accepts one serial bit per strobe and assembles the first seven bits, most significant first, into a candidate address. The eighth bit is taken as the read/write direction. Once all eight bits are in, it decides whether the byte selects this device. A byte selects the device either by equalling the programmed 7-bit own address, or by being the general-call byte 00h.

Each kind of match has its own enable. The own-address comparison runs only while the valid bit in the top position of the address register is 1. The general-call match runs only while its own enable is 1. A match sets a sticky new-match flag, which raises the interrupt line when both interrupt enables are on. If stall-after-address is enabled, a match also raises a stall request that holds the serial clock low until software releases it. A repeated start restarts capture, and a stop clears all match state. Driving the acknowledge and shifting data bytes belong to neighbouring logic.

Top module: `addr_matcher`

## Requirements
- R1: After reset, addr_match, gc_hit, new_match, rw_dir, stall_req, scl_hold and irq are all 0.
- R2: With own_addr_reg[7]=1, the eight strobed bits after a start, taken MSB first, match when the first seven equal own_addr_reg[6:0]. The first bit received is compared to bit 6. addr_match is 1 in the cycle after the eighth strobe.
- R3: With own_addr_reg[7]=0, a byte whose upper seven bits equal own_addr_reg[6:0] gives no own-address match.
- R4: When gc_en=1, an address byte of 00h sets both addr_match and gc_hit. When gc_en=0, the byte 00h gives no general-call match. The byte 01h is never a general call.
- R5: Every match sets new_match, which stays 1 until cleared. irq equals new_match AND nm_int_en AND int_en.
- R6: A match while stall_en=1 sets stall_req, and scl_hold follows it. Both stay 1 until a stall_release pulse. A byte that does not match never stalls.
- R7: A start pulse in the middle of a byte discards the bits already received, and capture restarts at bit 6.
- R8: A stop pulse clears addr_match, gc_hit, new_match and stall_req.
- R9: Bit strobes after the eighth bit, and strobes before any start, have no effect on the match outputs.
- R10: A pulse on nm_clr clears new_match without changing addr_match.
- R11: The eighth bit received appears on rw_dir in the same cycle that the match result appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_det | input | 1 | One-cycle pulse for a start or repeated start |
| stop_det | input | 1 | One-cycle pulse for a stop condition |
| bit_stb | input | 1 | Strobe that marks a valid received bit |
| bit_val | input | 1 | Received bit value |
| own_addr_reg | input | 8 | Bit 7 is the address-valid enable; bits 6:0 hold the own address |
| gc_en | input | 1 | General-call match enable |
| nm_int_en | input | 1 | New-match interrupt enable |
| int_en | input | 1 | Global interrupt enable |
| stall_en | input | 1 | Stall-after-address enable |
| stall_release | input | 1 | Software pulse that releases the stall |
| nm_clr | input | 1 | Software pulse that clears new_match |
| addr_match | output | 1 | The address byte selected this device |
| gc_hit | output | 1 | The match came from a general call |
| new_match | output | 1 | Sticky new-match status |
| rw_dir | output | 1 | Captured direction bit |
| stall_req | output | 1 | Stall request |
| scl_hold | output | 1 | Hold the serial clock low |
| irq | output | 1 | Interrupt request |

## Verification
The vector table covers several corner cases, each of which exposes a specific fault:

- The address byte 00h with the valid bit off and general call on. A design that wired the general-call match to the valid bit would miss here.
- A matching address with the valid bit clear. A design that ignored the valid bit would match wrongly.
- The byte 01h, which an LSB-first or seven-bit-only zero test would take for a general call.

The directed tests cover the remaining cases:

- A start pulse after three stray bits. A counter that is not reset would misalign the following address.
- Strobes that arrive before any start, or after the eighth bit, which a sloppy capture gate would turn into a match.
- A stop pulse, which must clear the stall.
- An interrupt-enable check, which catches an irq that ignores one of its two enables.

// File: rtl/addr_matcher.sv
module addr_matcher #(
  parameter int AW = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_det,
  input  logic        stop_det,
  input  logic        bit_stb,
  input  logic        bit_val,
  input  logic [AW:0] own_addr_reg,
  input  logic        gc_en,
  input  logic        nm_int_en,
  input  logic        int_en,
  input  logic        stall_en,
  input  logic        stall_release,
  input  logic        nm_clr,
  output logic        addr_match,
  output logic        gc_hit,
  output logic        new_match,
  output logic        rw_dir,
  output logic        stall_req,
  output logic        scl_hold,
  output logic        irq
);
  localparam int CW = $clog2(AW + 2);

  logic [AW-1:0] sh;
  logic [CW-1:0] cnt;
  logic          cap;

  wire last     = cap && bit_stb && !start_det && (cnt == CW'(AW));
  wire own_hit  = own_addr_reg[AW] && (sh == own_addr_reg[AW-1:0]);
  wire gc_now   = gc_en && (sh == '0) && !bit_val;
  wire any_hit  = own_hit || gc_now;

  assign scl_hold = stall_req;
  assign irq      = new_match && nm_int_en && int_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
      cnt <= '0;
      cap <= 1'b0;
      addr_match <= 1'b0;
      gc_hit <= 1'b0;
      new_match <= 1'b0;
      rw_dir <= 1'b0;
      stall_req <= 1'b0;
    end else if (stop_det) begin
      cap <= 1'b0;
      cnt <= '0;
      addr_match <= 1'b0;
      gc_hit <= 1'b0;
      new_match <= 1'b0;
      stall_req <= 1'b0;
    end else begin
      if (start_det) begin
        cap <= 1'b1;
        cnt <= '0;
        addr_match <= 1'b0;
        gc_hit <= 1'b0;
      end else if (cap && bit_stb) begin
        cnt <= cnt + 1'b1;
        if (last) begin
          cap <= 1'b0;
          rw_dir <= bit_val;
          addr_match <= any_hit;
          gc_hit <= gc_now;
        end else begin
          sh <= {sh[AW-2:0], bit_val};
        end
      end

      if (last && any_hit) new_match <= 1'b1;
      else if (nm_clr) new_match <= 1'b0;

      if (last && any_hit && stall_en) stall_req <= 1'b1;
      else if (stall_release) stall_req <= 1'b0;
    end
  end

  a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!addr_match && !gc_hit && !new_match && !stall_req));

  a_r5_nm_from_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(new_match) |-> addr_match);

  a_r6_stall_from_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_req) |-> (addr_match && $past(stall_en)));

  a_r4_gc_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gc_hit) |-> $past(gc_en));

  a_r3_own_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(addr_match) && !gc_hit) |-> $past(own_addr_reg[AW]));
endmodule

// File: tb/addr_matcher_tb.sv
module addr_matcher_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_det = 0, stop_det = 0, bit_stb = 0, bit_val = 0;
  logic [7:0] own_addr_reg = 8'h00;
  logic gc_en = 0, nm_int_en = 0, int_en = 0, stall_en = 0, stall_release = 0, nm_clr = 0;
  logic addr_match, gc_hit, new_match, rw_dir, stall_req, scl_hold, irq;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  addr_matcher u_dut (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .bit_stb(bit_stb), .bit_val(bit_val), .own_addr_reg(own_addr_reg),
    .gc_en(gc_en), .nm_int_en(nm_int_en), .int_en(int_en), .stall_en(stall_en),
    .stall_release(stall_release), .nm_clr(nm_clr),
    .addr_match(addr_match), .gc_hit(gc_hit), .new_match(new_match),
    .rw_dir(rw_dir), .stall_req(stall_req), .scl_hold(scl_hold), .irq(irq));

  // {valid, addr[6:0], gc_en, byte[7:0], exp_match, exp_gc, exp_rw}
  localparam logic [19:0] VEC [9] = '{
    {1'b1, 7'h5A, 1'b0, 8'hB4, 3'b100},
    {1'b1, 7'h5A, 1'b0, 8'hB5, 3'b101},
    {1'b1, 7'h5A, 1'b0, 8'hB6, 3'b000},
    {1'b0, 7'h5A, 1'b0, 8'hB4, 3'b000},
    {1'b0, 7'h5A, 1'b1, 8'h00, 3'b110},
    {1'b1, 7'h5A, 1'b0, 8'h00, 3'b000},
    {1'b0, 7'h00, 1'b1, 8'h01, 3'b001},
    {1'b1, 7'h00, 1'b1, 8'h00, 3'b110},
    {1'b1, 7'h7F, 1'b0, 8'hFF, 3'b101}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) begin bit_stb = 1'b1; bit_val = b; end
    @(negedge clk) bit_stb = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 addr_match", addr_match, 1'b0);
    chk("R1 new_match", new_match, 1'b0);
    chk("R1 stall/hold", stall_req | scl_hold, 1'b0);
    chk("R1 irq/rw/gc", irq | rw_dir | gc_hit, 1'b0);

    for (int v = 0; v < 9; v++) begin
      own_addr_reg = VEC[v][19:12];
      gc_en = VEC[v][11];
      pulse(start_det);
      send_byte(VEC[v][10:3]);
      chk($sformatf("R2/R3/R4 match vec%0d", v), addr_match, VEC[v][2]);
      chk($sformatf("R4 gc vec%0d", v), gc_hit, VEC[v][1]);
      chk($sformatf("R11 rw vec%0d", v), rw_dir, VEC[v][0]);
      pulse(stop_det);
    end

    own_addr_reg = 8'hDA; gc_en = 1'b0; int_en = 1'b1; nm_int_en = 1'b0;
    pulse(start_det); send_byte(8'hB4);
    chk("R5 new_match set", new_match, 1'b1);
    chk("R5 irq gated", irq, 1'b0);
    @(negedge clk) nm_int_en = 1'b1;
    #1 chk("R5 irq on", irq, 1'b1);
    int_en = 1'b0;
    #1 chk("R5 irq global gate", irq, 1'b0);
    int_en = 1'b1;
    pulse(nm_clr);
    chk("R10 new_match cleared", new_match, 1'b0);
    chk("R10 match kept", addr_match, 1'b1);
    send_byte(8'hB6);
    chk("R9 extra bits ignored", addr_match, 1'b1);
    pulse(stop_det);

    stall_en = 1'b1;
    pulse(start_det); send_byte(8'hB6);
    chk("R6 no stall on miss", stall_req | scl_hold, 1'b0);
    pulse(stop_det);
    pulse(start_det); send_byte(8'hB5);
    repeat (5) @(negedge clk);
    chk("R6 stall held", stall_req, 1'b1);
    chk("R6 scl_hold", scl_hold, 1'b1);
    pulse(stall_release);
    chk("R6 released", scl_hold, 1'b0);
    pulse(stop_det);

    pulse(start_det); send_byte(8'hB4);
    chk("R8 pre-stop", stall_req & new_match, 1'b1);
    pulse(stop_det);
    chk("R8 match cleared", addr_match, 1'b0);
    chk("R8 nm cleared", new_match, 1'b0);
    chk("R8 stall cleared", scl_hold, 1'b0);
    stall_en = 1'b0;

    send_byte(8'hB4);
    chk("R9 no start no match", addr_match | new_match, 1'b0);

    pulse(start_det);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    pulse(start_det);
    send_byte(8'hB5);
    chk("R7 restart match", addr_match, 1'b1);
    chk("R7 restart rw", rw_dir, 1'b1);
    pulse(stop_det);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule